// File: doc/BRIEF.md
# Guarded-Read Address Retry Monitor

This block sits beside a host bridge on a processor bus. Software programs an inclusive address window that covers a part of the PCI space where a processor read can deadlock against traffic moving the other way. When a processor issues a read into that window and the read is not retried, the block records it as the pending guarded read and stores the ID of the master that issued it.

While the guarded read is pending, the block answers other processor bus address tenures with a one-cycle address-retry pulse. One access is exempt: the first read outside the window, issued by the same master as the guarded read, which is taken to be the main-memory access that belongs to it. A control bit makes the exemption ignore the master ID. The pending state ends when the bridge reports that the read's data has completed, or when another agent retries the guarded read in its acknowledge cycle.

A small handshake toward the PCI side shows a memory request while a guarded read is pending, a memory acknowledge when the exempt access passes, and a pair of level outputs that say whether any competing access has been turned away since the read was captured. One control bit masks all of this handshake. A second bit turns the retry pulses on and off. All control bits come up at 0.

Top module: `rdg_guard`

## Requirements
- R1: After reset, the control bits, window base and window limit are 0, and `artry`, `hs_req`, `hs_ack`, `hs_lock` and `hs_nolock` are all 0.
- R2: A read (`abus_rd`=1) counts as guarded only if `win_base <= abus_addr <= win_limit`, with both bounds included, compared on the full address. Addresses one below the base or one above the limit do not count.
- R3: With the retry-enable bit (`cfg_ctrl[0]`) at 1 and a guarded read pending, every address tenure that is not exempt gets `artry`=1 in the cycle after the tenure, for exactly one cycle. Writes, other masters and further guarded reads are not exempt. With no read pending, `artry` stays 0.
- R4: Only one access is exempt per pending read: the first read outside the window that passes the ID test. It gets no retry, and `hs_ack` pulses in the cycle after it when the handshake is enabled. A second such read is retried.
- R5: With the ID-ignore bit (`cfg_ctrl[1]`) at 0, the exempt access must come from the master whose ID `abus_mid` matches the pending read. With the bit at 1, any master can take the exemption.
- R6: With `cfg_ctrl[0]`=0, `artry` is never asserted, but pending reads are still tracked.
- R7: With the handshake-enable bit (`cfg_ctrl[2]`) at 0, `hs_req`, `hs_ack`, `hs_lock` and `hs_nolock` all stay 0. With the bit at 1, `hs_req` is 1 while a read is pending. While a read is pending, `hs_lock` is 1 if any access has been retried since the read was captured, and `hs_nolock` is 1 otherwise.
- R8: A one-cycle `rd_done` ends the pending read. After that edge, accesses are no longer retried.
- R9: If `snoop_retry` is 1 in the acknowledge cycle (the cycle after the tenure) of the guarded read, the read is not left pending.
- R10: If `snoop_retry` is 1 in the acknowledge cycle of the exempt access, the exemption is made available again.
- R11: If `rd_done` and a new address tenure fall in the same cycle, the tenure sees no pending read. It is not retried, and if it is a guarded read it becomes the new pending read, with its own master ID.
- R12: Control and window values take effect in the cycle after `cfg_load`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_load | input | 1 | Loads the control bits and window bounds |
| cfg_ctrl | input | 3 | [0] retry enable, [1] ignore master ID, [2] handshake enable |
| cfg_base | input | AW | Inclusive lower bound of the window |
| cfg_limit | input | AW | Inclusive upper bound of the window |
| abus_valid | input | 1 | Address tenure strobe, one cycle per access |
| abus_addr | input | AW | Access address |
| abus_mid | input | IDW | Master ID of the access |
| abus_rd | input | 1 | 1 for a read, 0 for a write |
| snoop_retry | input | 1 | Retry from another agent, sampled in the acknowledge cycle |
| rd_done | input | 1 | Data of the pending guarded read has completed |
| artry | output | 1 | Address retry pulse in the acknowledge cycle |
| hs_req | output | 1 | Memory request toward the PCI side |
| hs_ack | output | 1 | Memory acknowledge pulse for the exempt access |
| hs_lock | output | 1 | Competing access was retried during the pending read |
| hs_nolock | output | 1 | Pending read has had no competing access |

## Verification
Two events can fall in the same cycle: the end of a pending read through `rd_done` and the address tenure of a new access. The bench drives both on one edge with a guarded read from a second master. It then checks three things: that tenure is not retried, the new read's master ID now decides the exemption, and a later out-of-window read from the old master is retried. A second overlap is a snoop retry landing on the acknowledge cycle of either the guarded read or the exempt access. The bench judges it by whether the next access is retried.

// File: rtl/rdg_pkg.sv
package rdg_pkg;

  typedef struct packed {
    logic hs_en;
    logic id_ignore;
    logic retry_en;
  } rdg_ctrl_t;

  localparam int CTRL_W = 3;

endpackage

// File: rtl/rdg_cfg.sv
module rdg_cfg
  import rdg_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cfg_load,
  input  logic [CTRL_W-1:0]      cfg_ctrl,
  input  logic [AW-1:0]          cfg_base,
  input  logic [AW-1:0]          cfg_limit,
  output rdg_ctrl_t              ctrl_q,
  output logic [AW-1:0]          base_q,
  output logic [AW-1:0]          limit_q
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      base_q  <= '0;
      limit_q <= '0;
    end else if (cfg_load) begin
      ctrl_q  <= rdg_ctrl_t'(cfg_ctrl);
      base_q  <= cfg_base;
      limit_q <= cfg_limit;
    end
  end

endmodule

// File: rtl/rdg_match.sv
module rdg_match
  import rdg_pkg::*;
#(
  parameter int AW  = 32,
  parameter int IDW = 2
) (
  input  logic            abus_valid,
  input  logic [AW-1:0]   abus_addr,
  input  logic [IDW-1:0]  abus_mid,
  input  logic            abus_rd,
  input  logic [AW-1:0]   base_q,
  input  logic [AW-1:0]   limit_q,
  input  rdg_ctrl_t       ctrl_q,
  input  logic            pend_live,
  input  logic [IDW-1:0]  pend_id,
  input  logic            own_used,
  output logic            exempt,
  output logic            retry_now,
  output logic            capture
);

  function automatic logic inside_window(input logic [AW-1:0] a,
                                         input logic [AW-1:0] lo,
                                         input logic [AW-1:0] hi);
    return (a >= lo) && (a <= hi);
  endfunction

  function automatic logic id_ok(input logic [IDW-1:0] who,
                                 input logic [IDW-1:0] owner,
                                 input logic           ignore);
    return ignore || (who == owner);
  endfunction

  logic in_win;

  always_comb begin
    in_win    = inside_window(abus_addr, base_q, limit_q);
    exempt    = abus_valid && pend_live && abus_rd && !in_win && !own_used &&
                id_ok(abus_mid, pend_id, ctrl_q.id_ignore);
    retry_now = abus_valid && pend_live && ctrl_q.retry_en && !exempt;
    capture   = abus_valid && abus_rd && in_win && !pend_live;
  end

endmodule

// File: rtl/rdg_track.sv
module rdg_track #(
  parameter int IDW = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            capture,
  input  logic [IDW-1:0]  abus_mid,
  input  logic            rd_done,
  input  logic            exempt,
  input  logic            retry_now,
  input  logic            snoop_retry,
  output logic            pending,
  output logic            pend_live,
  output logic [IDW-1:0]  pend_id,
  output logic            own_used,
  output logic            conflict,
  output logic            own_q
);

  logic cap_q;
  logic drop_pend;
  logic rearm_own;

  assign pend_live = pending && !rd_done;
  assign drop_pend = rd_done || (cap_q && snoop_retry);
  assign rearm_own = own_q && snoop_retry;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pending  <= 1'b0;
      pend_id  <= '0;
      own_used <= 1'b0;
      conflict <= 1'b0;
      cap_q    <= 1'b0;
      own_q    <= 1'b0;
    end else begin
      cap_q <= capture;
      own_q <= exempt;
      if (capture) begin
        pending  <= 1'b1;
        pend_id  <= abus_mid;
        own_used <= 1'b0;
        conflict <= 1'b0;
      end else begin
        if (drop_pend) pending <= 1'b0;
        if (exempt) own_used <= 1'b1;
        else if (rearm_own) own_used <= 1'b0;
        if (retry_now) conflict <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/rdg_guard.sv
module rdg_guard
  import rdg_pkg::*;
#(
  parameter int AW  = 32,
  parameter int IDW = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_load,
  input  logic [2:0]      cfg_ctrl,
  input  logic [AW-1:0]   cfg_base,
  input  logic [AW-1:0]   cfg_limit,
  input  logic            abus_valid,
  input  logic [AW-1:0]   abus_addr,
  input  logic [IDW-1:0]  abus_mid,
  input  logic            abus_rd,
  input  logic            snoop_retry,
  input  logic            rd_done,
  output logic            artry,
  output logic            hs_req,
  output logic            hs_ack,
  output logic            hs_lock,
  output logic            hs_nolock
);

  rdg_ctrl_t        ctrl_q;
  logic [AW-1:0]    base_q;
  logic [AW-1:0]    limit_q;
  logic             pending;
  logic             pend_live;
  logic [IDW-1:0]   pend_id;
  logic             own_used;
  logic             conflict;
  logic             own_q;
  logic             exempt;
  logic             retry_now;
  logic             capture;
  logic             artry_q;

  rdg_cfg #(.AW(AW)) u_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_load (cfg_load),
    .cfg_ctrl (cfg_ctrl),
    .cfg_base (cfg_base),
    .cfg_limit(cfg_limit),
    .ctrl_q   (ctrl_q),
    .base_q   (base_q),
    .limit_q  (limit_q)
  );

  rdg_match #(.AW(AW), .IDW(IDW)) u_match (
    .abus_valid(abus_valid),
    .abus_addr (abus_addr),
    .abus_mid  (abus_mid),
    .abus_rd   (abus_rd),
    .base_q    (base_q),
    .limit_q   (limit_q),
    .ctrl_q    (ctrl_q),
    .pend_live (pend_live),
    .pend_id   (pend_id),
    .own_used  (own_used),
    .exempt    (exempt),
    .retry_now (retry_now),
    .capture   (capture)
  );

  rdg_track #(.IDW(IDW)) u_track (
    .clk        (clk),
    .rst_n      (rst_n),
    .capture    (capture),
    .abus_mid   (abus_mid),
    .rd_done    (rd_done),
    .exempt     (exempt),
    .retry_now  (retry_now),
    .snoop_retry(snoop_retry),
    .pending    (pending),
    .pend_live  (pend_live),
    .pend_id    (pend_id),
    .own_used   (own_used),
    .conflict   (conflict),
    .own_q      (own_q)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) artry_q <= 1'b0;
    else        artry_q <= retry_now;
  end

  assign artry     = artry_q;
  assign hs_req    = ctrl_q.hs_en && pending;
  assign hs_ack    = ctrl_q.hs_en && own_q;
  assign hs_lock   = ctrl_q.hs_en && pending && conflict;
  assign hs_nolock = ctrl_q.hs_en && pending && !conflict;

endmodule

// File: rtl/rdg_guard_chk.sv
module rdg_guard_chk (
  input logic clk,
  input logic rst_n,
  input logic abus_valid,
  input logic rd_done,
  input logic capture,
  input logic pend_live,
  input logic pending,
  input logic retry_en,
  input logic hs_en,
  input logic artry,
  input logic hs_req,
  input logic hs_ack,
  input logic hs_lock,
  input logic hs_nolock
);

  AST_RETRY_NEEDS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    artry |-> $past(pend_live)); // R3
  AST_RETRY_AFTER_TENURE: assert property (@(posedge clk) disable iff (!rst_n)
    artry |-> $past(abus_valid)); // R3
  AST_RETRY_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    artry |-> $past(retry_en)); // R6
  AST_ACK_NOT_RETRIED: assert property (@(posedge clk) disable iff (!rst_n)
    !(artry && hs_ack)); // R4
  AST_LOCK_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(hs_lock && hs_nolock)); // R7
  AST_HS_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    !hs_en |-> !(hs_req || hs_ack || hs_lock || hs_nolock)); // R7
  AST_DONE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_done && !capture) |=> !pending); // R8

endmodule

bind rdg_guard rdg_guard_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .abus_valid(abus_valid),
  .rd_done   (rd_done),
  .capture   (capture),
  .pend_live (pend_live),
  .pending   (pending),
  .retry_en  (ctrl_q.retry_en),
  .hs_en     (ctrl_q.hs_en),
  .artry     (artry),
  .hs_req    (hs_req),
  .hs_ack    (hs_ack),
  .hs_lock   (hs_lock),
  .hs_nolock (hs_nolock)
);

// File: tb/rdg_guard_tb_top.sv
`timescale 1ns/1ps
module rdg_guard_tb_top;

  localparam int AW  = 32;
  localparam int IDW = 2;
  localparam logic [31:0] WBASE = 32'h4000_0000;
  localparam logic [31:0] WLIM  = 32'h4000_00FF;
  localparam logic [31:0] OUTA  = 32'h1000_0000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_load = 1'b0;
  logic [2:0] cfg_ctrl = '0;
  logic [AW-1:0] cfg_base = '0, cfg_limit = '0;
  logic abus_valid = 1'b0;
  logic [AW-1:0] abus_addr = '0;
  logic [IDW-1:0] abus_mid = '0;
  logic abus_rd = 1'b0;
  logic snoop_retry = 1'b0;
  logic rd_done = 1'b0;
  logic artry, hs_req, hs_ack, hs_lock, hs_nolock;

  always #2.5 clk = ~clk;

  rdg_guard #(.AW(AW), .IDW(IDW)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_ctrl(cfg_ctrl),
    .cfg_base(cfg_base), .cfg_limit(cfg_limit), .abus_valid(abus_valid),
    .abus_addr(abus_addr), .abus_mid(abus_mid), .abus_rd(abus_rd),
    .snoop_retry(snoop_retry), .rd_done(rd_done), .artry(artry),
    .hs_req(hs_req), .hs_ack(hs_ack), .hs_lock(hs_lock), .hs_nolock(hs_nolock)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  // bench-side model
  bit c_ret, c_ign, c_hs;
  logic [31:0] c_base, c_lim;
  bit m_pend, m_used, m_conf;
  logic [IDW-1:0] m_pid;

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic check_state(input string tag);
    check(hs_req == (c_hs && m_pend), tag, "hs_req", hs_req, c_hs && m_pend);
    check(hs_lock == (c_hs && m_pend && m_conf), tag, "hs_lock", hs_lock,
          c_hs && m_pend && m_conf);
    check(hs_nolock == (c_hs && m_pend && !m_conf), tag, "hs_nolock", hs_nolock,
          c_hs && m_pend && !m_conf);
  endtask

  task automatic set_cfg(input logic [2:0] ctl, input logic [31:0] b,
                         input logic [31:0] l);
    cfg_load = 1'b1; cfg_ctrl = ctl; cfg_base = b; cfg_limit = l;
    @(negedge clk);
    cfg_load = 1'b0;
    c_ret = ctl[0]; c_ign = ctl[1]; c_hs = ctl[2]; c_base = b; c_lim = l;
  endtask

  task automatic done_pulse();
    rd_done = 1'b1;
    @(negedge clk);
    rd_done = 1'b0;
    m_pend = 0;
  endtask

  // one address tenure; optional snoop in the ack cycle, optional rd_done
  // in the tenure cycle
  task automatic access(input logic [31:0] a, input logic [IDW-1:0] id,
                        input bit rd, input bit snoop, input bit done,
                        input string tag);
    bit in_w, live, ex, eretry, cap;
    in_w   = (a >= c_base) && (a <= c_lim);
    live   = m_pend && !done;
    ex     = live && rd && !in_w && !m_used && (c_ign || id == m_pid);
    eretry = c_ret && live && !ex;
    cap    = rd && in_w && !live;
    abus_valid = 1'b1; abus_addr = a; abus_mid = id; abus_rd = rd;
    rd_done = done;
    @(negedge clk);
    abus_valid = 1'b0; rd_done = 1'b0;
    check(artry == eretry, tag, "artry", artry, eretry);
    check(hs_ack == (c_hs && ex), tag, "hs_ack", hs_ack, c_hs && ex);
    if (done) m_pend = 0;
    if (ex) m_used = 1;
    if (eretry) m_conf = 1;
    if (cap) begin m_pend = 1; m_pid = id; m_used = 0; m_conf = 0; end
    snoop_retry = snoop;
    @(negedge clk);
    snoop_retry = 1'b0;
    check(artry == 1'b0, "R3", "artry pulse width", artry, 0);
    if (snoop && cap) m_pend = 0;
    if (snoop && ex) m_used = 0;
    check_state(tag);
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    c_ret = 0; c_ign = 0; c_hs = 0; c_base = '0; c_lim = '0;
    m_pend = 0; m_used = 0; m_conf = 0; m_pid = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(artry == 0, "R1", "artry", artry, 0);
    check(hs_ack == 0, "R1", "hs_ack", hs_ack, 0);
    check_state("R1");
    // reset window 0..0: address 0 read is guarded, but retry is off
    access(32'h0, 0, 1, 0, 0, "R1");
    access(OUTA, 1, 0, 0, 0, "R1");
    done_pulse();

    // config takes effect one cycle after load
    set_cfg(3'b101, WBASE, WLIM);
    access(WBASE, 0, 1, 0, 0, "R12");
    access(OUTA, 1, 0, 0, 0, "R12");
    done_pulse();

    // sweep every control combination over a fixed scenario
    for (int m = 0; m < 8; m++) begin
      set_cfg(m[2:0], WBASE, WLIM);
      done_pulse();
      access(WBASE + 32'h10, 0, 1, 0, 0, "R2");
      access(OUTA, 1, 1, 0, 0, "R5");
      access(OUTA, 0, 0, 0, 0, "R3");
      access(OUTA + 32'h40, 0, 1, 0, 0, "R4");
      access(OUTA + 32'h80, 0, 1, 0, 0, "R4");
      access(WBASE + 32'h20, 2, 1, 0, 0, m[0] ? "R3" : "R6");
      access(OUTA, 3, 0, 0, 0, m[2] ? "R7" : "R6");
      done_pulse();
      check_state("R8");
      access(OUTA, 1, 0, 0, 0, "R8");
    end

    // inclusive boundaries of the window
    set_cfg(3'b101, WBASE, WLIM);
    for (int k = 0; k < 6; k++) begin
      logic [31:0] a;
      case (k)
        0: a = WBASE - 1;
        1: a = WBASE;
        2: a = WLIM;
        3: a = WLIM + 1;
        4: a = 32'h0;
        default: a = 32'hFFFF_FFFF;
      endcase
      done_pulse();
      access(a, 0, 1, 0, 0, "R2");
      access(OUTA, 1, 0, 0, 0, "R2");
    end

    // snoop retry of the guarded read
    done_pulse();
    access(WBASE, 0, 1, 1, 0, "R9");
    access(OUTA, 1, 0, 0, 0, "R9");

    // snoop retry of the exempt access re-arms the exemption
    done_pulse();
    access(WBASE, 0, 1, 0, 0, "R10");
    access(OUTA, 0, 1, 1, 0, "R10");
    access(OUTA, 0, 1, 0, 0, "R10");
    access(OUTA, 0, 1, 0, 0, "R10");

    // rd_done and a new guarded read in the same cycle
    done_pulse();
    access(WBASE, 0, 1, 0, 0, "R11");
    access(WBASE + 32'h8, 1, 1, 0, 1, "R11");
    access(OUTA, 0, 1, 0, 0, "R11");
    access(OUTA, 1, 1, 0, 0, "R11");
    // rd_done with an outside access in the same cycle
    access(OUTA, 2, 0, 0, 1, "R11");
    access(OUTA, 3, 0, 0, 0, "R8");

    // ID ignored: another master takes the exemption
    set_cfg(3'b111, WBASE, WLIM);
    done_pulse();
    access(WBASE, 0, 1, 0, 0, "R5");
    access(OUTA, 2, 1, 0, 0, "R5");
    access(OUTA, 0, 1, 0, 0, "R4");
    done_pulse();

    finished = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule